// File: doc/BRIEF.md
# Asynchronous Bus Termination Arbiter

This block lives inside a bus master and decides how an asynchronous bus cycle ends. The master raises a one-clock start request; from then on the block watches three active-low handshake lines coming from the slave side: a two-bit transfer acknowledge, a bus-error line and a halt line. All of them are brought into the clock domain through a two-flop synchronizer. A bus-state counter produces a sample strobe once per even bus state. The first strobe at which an acknowledge or a bus error is seen becomes state n. The strobe one even state later becomes state n+2.

From the two samples the block issues exactly one single-clock outcome pulse. The possible outcomes are normal completion, completion followed by a halt, an immediate bus-error exception, a deferred (late) bus-error exception, and a retry. While no acknowledge and no bus error arrive, the block keeps inserting wait states with no limit. After a halt or a retry outcome it keeps `busy` high until the synchronized halt line is negated again. The master uses that to hold off its next cycle.

Top module: `bus_term_arbiter`

## Requirements
- R1: While `rst` is high and in the first clock after it, `busy` is low and all five outcome pulses are low.
- R2: A `cycle_start` seen at a clock edge while `busy` is low raises `busy` after that edge. A `cycle_start` seen while `busy` is high is ignored: it adds no extra outcome pulse.
- R3: A change on a handshake input becomes visible to the decision logic two clock edges later. Samples are taken only on strobe edges: the 4th, 8th, 12th, ... edge after the edge that accepted the start (`EVEN_PERIOD` = 4). An outcome pulse never appears before the clock that follows the n+2 strobe.
- R4: At a strobe where neither acknowledge nor bus error is asserted, the block inserts a wait state and keeps waiting indefinitely. Halt asserted alone does not open state n.
- R5: Acknowledge at n, with bus error negated at n and n+2 and halt negated at n, gives a `done` pulse and `busy` falls with it. The acknowledge value at n+2 does not matter.
- R6: Acknowledge and halt at n, with bus error negated at n and n+2, gives a `halted` pulse. `busy` stays high until the synchronized halt is negated.
- R7: Bus error at n with halt negated at n gives a `berr_exception` pulse, whether or not acknowledge is present at n.
- R8: Acknowledge alone at n (bus error negated), then bus error without halt at n+2, gives a `berr_deferred` pulse. This takes priority over a halt seen at n.
- R9: Bus error together with halt, either at n or at n+2 after an acknowledge at n, gives a `retry` pulse. `busy` then stays high until the synchronized halt is negated.
- R10: At most one outcome pulse is high in any clock, each lasts one clock, and it appears in the clock right after the n+2 strobe edge. After `done` or either bus-error pulse, `busy` is already low in that same clock.
- R11: `ack_n` = 2'b11 means no acknowledge. The values 2'b10, 2'b01 and 2'b00 each count as an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_start | input | 1 | One-clock request to begin a bus cycle |
| ack_n | input | 2 | Active-low transfer acknowledge, asynchronous |
| berr_n | input | 1 | Active-low bus error, asynchronous |
| halt_n | input | 1 | Active-low halt, asynchronous |
| busy | output | 1 | Cycle in progress or waiting for halt release |
| done | output | 1 | Pulse: normal completion |
| halted | output | 1 | Pulse: completion, then halt |
| berr_exception | output | 1 | Pulse: bus-error exception taken now |
| berr_deferred | output | 1 | Pulse: bus-error exception from a late error |
| retry | output | 1 | Pulse: cycle to be retried after halt release |

## Verification
Counted from the edge that accepts the start, the n-th sample falls on edge 4w+4 after w wait states. A handshake value therefore has to be driven before edge 4w+2 to be seen there. The outcome pulse is due in the clock after edge 4w+8, and a halt release lowers `busy` three clocks after the halt line is negated. The bench drives its patterns on that schedule, confirms that no pulse is present one clock early and that the expected one is present at the due clock, and it compares every output each clock against a behavioural model that steps the same latencies.

// File: rtl/bta_pkg.sv
package bta_pkg;

    localparam int ACK_W = 2;

    // Active-high view of the synchronized handshake lines
    typedef struct packed {
        logic halt;
        logic berr;
        logic ack;
    } ctl_t;

    typedef enum logic [2:0] {
        OC_NONE,
        OC_DONE,
        OC_HALT,
        OC_BERR_NOW,
        OC_BERR_LATE,
        OC_RETRY
    } outcome_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_HOLD
    } state_e;

    typedef struct packed {
        logic done;
        logic halted;
        logic berr_now;
        logic berr_late;
        logic retry;
    } pulse_t;

    function automatic ctl_t from_pins(logic [ACK_W-1:0] ack_n, logic berr_n, logic halt_n);
        ctl_t c;
        c.ack  = ~&ack_n;
        c.berr = ~berr_n;
        c.halt = ~halt_n;
        return c;
    endfunction

    // a: sample at state n, b: sample at state n+2
    function automatic outcome_e decide(ctl_t a, ctl_t b);
        if (a.berr && a.halt) return OC_RETRY;
        if (a.berr)           return OC_BERR_NOW;
        if (b.berr && b.halt) return OC_RETRY;
        if (b.berr)           return OC_BERR_LATE;
        if (a.halt)           return OC_HALT;
        return OC_DONE;
    endfunction

    function automatic pulse_t to_pulses(outcome_e oc);
        pulse_t p;
        p           = '0;
        p.done      = (oc == OC_DONE);
        p.halted    = (oc == OC_HALT);
        p.berr_now  = (oc == OC_BERR_NOW);
        p.berr_late = (oc == OC_BERR_LATE);
        p.retry     = (oc == OC_RETRY);
        return p;
    endfunction

    function automatic logic waits_for_release(outcome_e oc);
        return (oc == OC_HALT) || (oc == OC_RETRY);
    endfunction

endpackage

// File: rtl/bta_sync.sv
module bta_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

    generate
        if (STAGES == 2) begin : g_lat_chk
            // two-edge latency from pin to decision logic
            p_sync_latency_r3: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, 2)));
        end
    endgenerate

endmodule

// File: rtl/bta_phase.sv
module bta_phase #(
    parameter int PERIOD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic strobe
);

    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign strobe = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= strobe ? '0 : cnt + 1'b1;
        end
    end

    generate
        if (PERIOD > 1) begin : g_space_chk
            p_strobe_gap_r3: assert property (@(posedge clk) disable iff (rst)
                strobe |=> !strobe);
            p_clear_no_strobe_r3: assert property (@(posedge clk) disable iff (rst)
                clear |=> !strobe);
        end
    endgenerate

endmodule

// File: rtl/bta_fsm.sv
module bta_fsm
    import bta_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  ctl_t   ctl,
    input  logic   strobe,
    output logic   phase_clear,
    output logic   phase_run,
    output logic   busy,
    output pulse_t pulses
);

    state_e   st;
    ctl_t     first;
    outcome_e verdict;

    always_comb verdict = decide(first, ctl);

    assign busy        = (st != ST_IDLE);
    assign phase_clear = (st == ST_IDLE) && start;
    assign phase_run   = (st == ST_FIRST) || (st == ST_SECOND);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            first  <= '0;
            pulses <= '0;
        end else begin
            pulses <= '0;
            unique case (st)
                ST_IDLE: begin
                    if (start) st <= ST_FIRST;
                end
                ST_FIRST: begin
                    if (strobe && (ctl.ack || ctl.berr)) begin
                        first <= ctl;
                        st    <= ST_SECOND;
                    end
                end
                ST_SECOND: begin
                    if (strobe) begin
                        pulses <= to_pulses(verdict);
                        st     <= waits_for_release(verdict) ? ST_HOLD : ST_IDLE;
                    end
                end
                ST_HOLD: begin
                    if (!ctl.halt) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulses));
    p_after_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        (|pulses) |-> $past(strobe));
    p_done_free_r5: assert property (@(posedge clk) disable iff (rst)
        pulses.done |-> !busy);
    p_berr_free_r7: assert property (@(posedge clk) disable iff (rst)
        (pulses.berr_now || pulses.berr_late) |-> !busy);
    p_retry_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (pulses.retry || pulses.halted) |-> busy);
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

endmodule

// File: rtl/bus_term_arbiter.sv
module bus_term_arbiter
    import bta_pkg::*;
#(
    parameter int EVEN_PERIOD = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cycle_start,
    input  logic [ACK_W-1:0] ack_n,
    input  logic             berr_n,
    input  logic             halt_n,
    output logic             busy,
    output logic             done,
    output logic             halted,
    output logic             berr_exception,
    output logic             berr_deferred,
    output logic             retry
);

    localparam int PIN_W = ACK_W + 2;

    logic [PIN_W-1:0] pins_q;
    ctl_t             ctl;
    logic             strobe, phase_clear, phase_run;
    pulse_t           pulses;

    bta_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ack_n, berr_n, halt_n}),
        .q   (pins_q)
    );

    assign ctl = from_pins(pins_q[PIN_W-1:2], pins_q[1], pins_q[0]);

    bta_phase #(.PERIOD(EVEN_PERIOD)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .clear  (phase_clear),
        .run    (phase_run),
        .strobe (strobe)
    );

    bta_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (cycle_start),
        .ctl         (ctl),
        .strobe      (strobe),
        .phase_clear (phase_clear),
        .phase_run   (phase_run),
        .busy        (busy),
        .pulses      (pulses)
    );

    assign done           = pulses.done;
    assign halted         = pulses.halted;
    assign berr_exception = pulses.berr_now;
    assign berr_deferred  = pulses.berr_late;
    assign retry          = pulses.retry;

endmodule

// File: tb/bus_term_arbiter_tb.sv
`timescale 1ns/100ps
module bus_term_arbiter_tb;

    localparam int PER = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cycle_start = 1'b0;
    logic [1:0] ack_n = 2'b11;
    logic       berr_n = 1'b1;
    logic       halt_n = 1'b1;
    logic       busy, done, halted, berr_exception, berr_deferred, retry;

    always #2 clk = ~clk;   // 250 MHz

    bus_term_arbiter u_dut (
        .clk(clk), .rst(rst), .cycle_start(cycle_start),
        .ack_n(ack_n), .berr_n(berr_n), .halt_n(halt_n),
        .busy(busy), .done(done), .halted(halted),
        .berr_exception(berr_exception), .berr_deferred(berr_deferred),
        .retry(retry)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // Pulse vector order: {done, halted, berr_exception, berr_deferred, retry}
    logic [2:0] m_p1 = 0, m_p2 = 0, m_a = 0, m_s; // {halt, berr, ack}
    int         m_st = 0, m_cnt = 0;
    logic [4:0] m_pl = 0;
    logic       m_stb;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_p1 = 0; m_p2 = 0; m_pl = 0; m_a = 0;
        end else begin
            m_s   = m_p2;
            m_stb = (m_cnt == PER - 1) && (m_st == 1 || m_st == 2);
            m_pl  = 0;
            if (m_st == 0) begin
                if (cycle_start) begin m_st = 1; m_cnt = 0; end
            end else if (m_st == 1) begin
                if (m_stb && (m_s[0] || m_s[1])) begin m_a = m_s; m_st = 2; end
                m_cnt = m_stb ? 0 : m_cnt + 1;
            end else if (m_st == 2) begin
                if (m_stb) begin
                    if (m_a[1] && m_a[2])      m_pl = 5'b00001;
                    else if (m_a[1])           m_pl = 5'b00100;
                    else if (m_s[1] && m_s[2]) m_pl = 5'b00001;
                    else if (m_s[1])           m_pl = 5'b00010;
                    else if (m_a[2])           m_pl = 5'b01000;
                    else                       m_pl = 5'b10000;
                    m_st = (m_pl[3] || m_pl[0]) ? 3 : 0;
                end
                m_cnt = m_stb ? 0 : m_cnt + 1;
            end else begin
                if (!m_s[2]) m_st = 0;
            end
            m_p2 = m_p1;
            m_p1 = {~halt_n, ~berr_n, ~&ack_n};
        end
    end

    // per-clock comparison and pulse counting
    int pc [5];
    always @(negedge clk) begin
        logic [4:0] dv;
        dv = {done, halted, berr_exception, berr_deferred, retry};
        for (int i = 0; i < 5; i++) if (dv[i]) pc[4-i]++;
        if (!finished) begin
            check(busy == (m_st != 0), "R2 busy vs model", busy, m_st != 0);
            check(done == m_pl[4], "R5 done vs model", done, m_pl[4]);
            check(halted == m_pl[3], "R6 halted vs model", halted, m_pl[3]);
            check(berr_exception == m_pl[2], "R7 berr_exception vs model", berr_exception, m_pl[2]);
            check(berr_deferred == m_pl[1], "R8 berr_deferred vs model", berr_deferred, m_pl[1]);
            check(retry == m_pl[0], "R9 retry vs model", retry, m_pl[0]);
        end
    end

    function automatic int total();
        return pc[0] + pc[1] + pc[2] + pc[3] + pc[4];
    endfunction

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic drive(input logic [1:0] a, input logic b, input logic h);
        ack_n = a; berr_n = ~b; halt_n = ~h;
    endtask

    // exp index: 0 done, 1 halted, 2 berr_exception, 3 berr_deferred, 4 retry
    task automatic scenario(input int w, input bit pre_halt,
                            input logic [1:0] a_ack, input logic a_berr, input logic a_halt,
                            input logic [1:0] b_ack, input logic b_berr, input logic b_halt,
                            input int exp, input bit restart, input string req);
        int t;
        for (int i = 0; i < 5; i++) pc[i] = 0;
        drive(2'b11, 1'b0, pre_halt);
        cycle_start = 1'b1;
        step();                 // start accepted at edge E0
        cycle_start = 1'b0;
        t = 0;
        if (restart && w > 0) begin
            step(); t++;
            cycle_start = 1'b1;
            step(); t++;
            cycle_start = 1'b0;
        end
        while (t < PER * w) begin step(); t++; end
        // R4: still waiting, nothing issued
        check(busy == 1'b1, "R4 busy during wait states", busy, 1);
        check(total() == 0, "R4 no outcome during wait states", total(), 0);
        drive(a_ack, a_berr, a_halt);
        repeat (PER) step();
        drive(b_ack, b_berr, b_halt);
        repeat (PER - 1) step();
        check(total() == 0, "R3 no pulse before due clock", total(), 0);
        step();
        check(pc[exp] == 1, {req, " outcome at due clock"}, pc[exp], 1);
        check(total() == 1, "R10 single pulse at due clock", total(), 1);
        if (exp == 1 || exp == 4) begin
            check(busy == 1'b1, {req, " busy held after outcome"}, busy, 1);
            repeat (4) step();
            check(busy == 1'b1, {req, " busy held while halt asserted"}, busy, 1);
            drive(2'b11, 1'b0, 1'b0);
            repeat (2) step();
            check(busy == 1'b1, {req, " busy before release seen"}, busy, 1);
            step();
            check(busy == 1'b0, {req, " busy released after halt negated"}, busy, 0);
        end else begin
            check(busy == 1'b0, "R10 busy low with final pulse", busy, 0);
            drive(2'b11, 1'b0, 1'b0);
        end
        repeat (6) step();
        check(total() == 1, "R2 R10 exactly one outcome per cycle", total(), 1);
    endtask

    initial begin
        repeat (3) step();
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check({done, halted, berr_exception, berr_deferred, retry} == 0,
              "R1 pulses in reset", {done, halted, berr_exception, berr_deferred, retry}, 0);
        rst = 1'b0;
        step();
        check(busy == 1'b0, "R1 busy after reset", busy, 0);

        // R5 / R11 normal, various acknowledge encodings
        scenario(0, 0, 2'b10, 0, 0, 2'b10, 0, 0, 0, 0, "R5 R11 ack 10");
        scenario(2, 0, 2'b01, 0, 0, 2'b11, 0, 0, 0, 1, "R5 R11 ack 01 wait");
        scenario(1, 0, 2'b00, 0, 0, 2'b00, 0, 1, 0, 0, "R5 R11 ack 00 late halt");
        // R6 halt
        scenario(0, 0, 2'b00, 0, 1, 2'b00, 0, 1, 1, 0, "R6 halt");
        // R4 halt alone does not open n
        scenario(3, 1, 2'b10, 0, 1, 2'b10, 0, 1, 1, 1, "R4 R6 early halt");
        // R7 bus error
        scenario(0, 0, 2'b11, 1, 0, 2'b11, 1, 0, 2, 0, "R7 berr alone");
        scenario(1, 0, 2'b00, 1, 0, 2'b11, 0, 0, 2, 0, "R7 berr with ack");
        // R8 late bus error
        scenario(0, 0, 2'b01, 0, 0, 2'b01, 1, 0, 3, 0, "R8 late berr");
        scenario(2, 0, 2'b00, 0, 1, 2'b00, 1, 0, 3, 1, "R8 late berr over halt");
        // R9 retry
        scenario(0, 0, 2'b11, 1, 1, 2'b11, 1, 1, 4, 0, "R9 retry at n");
        scenario(1, 0, 2'b10, 0, 0, 2'b10, 1, 1, 4, 0, "R9 retry at n+2");
        // R4 long wait then normal
        scenario(12, 0, 2'b00, 0, 0, 2'b00, 0, 0, 0, 1, "R4 R5 long wait");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule